// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block sequences a processor bus cycle through its T1, T2, T3 and T4 states and stretches the cycle for slow memories or peripherals. It stretches the cycle by inserting wait states (repeats of T3) before T4. A start strobe opens a cycle. At that start edge the block captures the settings of the chip-select region that the address hit: a 2-bit internal wait count, and a flag that says whether the external ready line counts for that region.

The external ready line is asynchronous, so the block synchronizes it before using it. An external circuit can keep the line high and pull it low only to ask for waits (normally-ready). It can also hold the line low and raise it only when the device can finish (normally-not-ready). The block handles both styles the same way: when the ready line is enabled, T4 begins only after the internal count has run out and the synchronized line is high. A one-clock strobe marks T4, which is the cycle in which read data is captured.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted, and just after it is released, `bus_state` is IDLE (code 0) and `data_latch` is low.
- R2: The state codes are IDLE=0, T1=1, T2=2, T3=3, WAIT=4 and T4=5. A `cyc_start` sampled high in IDLE gives T1 in the next clock, then T2, then T3.
- R3: In IDLE without `cyc_start` the state stays IDLE. A `cyc_start` that arrives while a cycle is running is ignored, and the state still returns to IDLE after T4.
- R4: After T3 the block spends exactly W clocks in WAIT before any ready test. W is 0 to 3 and comes from bits [2i+1:2i] of `wait_cfg` for the selected region i. With W=0 and ready disabled the cycle is four clocks long: T1, T2, T3, T4.
- R5: Bit i of `region_hit` selects region i. If several bits are set, the lowest index wins. If no bit is set, the cycle uses W=0 and ignores the ready line.
- R6: When bit i of `rdy_en_cfg` is 0 for the selected region, `ext_ready` has no effect on the length of the cycle.
- R7: When the ready line is enabled, the block leaves T3 or WAIT for T4 at a clock edge only if the internal count has expired and `ext_ready` was high at the edge two clocks earlier (two-flop synchronizer). Otherwise it stays in WAIT.
- R8: `data_latch` is high exactly during the one-clock T4 state, and T4 is always followed by IDLE.
- R9: The wait count and the ready enable are captured at the edge that accepts `cyc_start`. Changing `wait_cfg`, `rdy_en_cfg` or `region_hit` later in the cycle has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Bus-cycle start strobe |
| region_hit | input | NUM_REGIONS | Chip-select region hit vector |
| wait_cfg | input | NUM_REGIONS*WAIT_W | Packed per-region wait counts |
| rdy_en_cfg | input | NUM_REGIONS | Per-region external-ready enable |
| ext_ready | input | 1 | Asynchronous external ready |
| bus_state | output | 3 | Current bus state code |
| data_latch | output | 1 | Data capture strobe, high in T4 |

## Verification
The bench measures how many clocks pass from T1 to the strobe under several input patterns. Cycles with the ready line held high separate the internal count from the ready logic. Normally-not-ready patterns, where the line rises late, show that the line delays T4 only past the count and with the two-clock synchronizer lag. Normally-ready patterns, with a low pulse placed before, across or after the count's expiry, show that only samples taken after expiry matter. The same patterns with the enable cleared show that the ready line is ignored. Directed cases with several region bits set, with no region bit set, with configuration changed mid-cycle and with a stray start strobe separate region priority, capture timing and the idle-only start.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
   typedef enum logic [2:0] {
      BS_IDLE = 3'd0,
      BS_T1   = 3'd1,
      BS_T2   = 3'd2,
      BS_T3   = 3'd3,
      BS_WAIT = 3'd4,
      BS_T4   = 3'd5
   } bus_state_e;
endpackage

// File: rtl/bwg_ready_sync.sv
module bwg_ready_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], async_in};
   end

   assign sync_out = sr[STAGES-1];
endmodule

// File: rtl/bwg_cfg_select.sv
module bwg_cfg_select #(
   parameter int NUM_REGIONS = 4,
   parameter int WAIT_W      = 2
) (
   input  logic [NUM_REGIONS-1:0]        region_hit,
   input  logic [NUM_REGIONS*WAIT_W-1:0] wait_cfg,
   input  logic [NUM_REGIONS-1:0]        rdy_en_cfg,
   output logic [WAIT_W-1:0]             sel_wait,
   output logic                          sel_rdy_en
);
   logic [WAIT_W-1:0] field [NUM_REGIONS];

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_unpack
      assign field[g] = wait_cfg[g*WAIT_W +: WAIT_W];
   end

   // scan downward so the lowest set index is applied last and wins
   always_comb begin
      sel_wait   = '0;
      sel_rdy_en = 1'b0;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (region_hit[i]) begin
            sel_wait   = field[i];
            sel_rdy_en = rdy_en_cfg[i];
         end
      end
   end
endmodule

// File: rtl/bwg_sequencer.sv
module bwg_sequencer
   import bwg_pkg::*;
#(
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [WAIT_W-1:0] ld_wait,
   input  logic              ld_rdy_en,
   input  logic              rdy_sync,
   output bus_state_e        state
);
   bus_state_e        state_nx;
   logic [WAIT_W-1:0] cnt, cnt_nx;
   logic              rdy_use, rdy_use_nx;
   logic              may_finish;

   assign may_finish = (cnt == '0) && (!rdy_use || rdy_sync);

   always_comb begin
      state_nx   = state;
      cnt_nx     = cnt;
      rdy_use_nx = rdy_use;
      unique case (state)
         BS_IDLE: if (cyc_start) begin
            state_nx   = BS_T1;
            cnt_nx     = ld_wait;
            rdy_use_nx = ld_rdy_en;
         end
         BS_T1: state_nx = BS_T2;
         BS_T2: state_nx = BS_T3;
         BS_T3, BS_WAIT: begin
            if (may_finish) state_nx = BS_T4;
            else begin
               state_nx = BS_WAIT;
               if (cnt != '0) cnt_nx = cnt - 1'b1;
            end
         end
         BS_T4:   state_nx = BS_IDLE;
         default: state_nx = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BS_IDLE;
         cnt     <= '0;
         rdy_use <= 1'b0;
      end else begin
         state   <= state_nx;
         cnt     <= cnt_nx;
         rdy_use <= rdy_use_nx;
      end
   end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import bwg_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int WAIT_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cyc_start,
   input  logic [NUM_REGIONS-1:0]        region_hit,
   input  logic [NUM_REGIONS*WAIT_W-1:0] wait_cfg,
   input  logic [NUM_REGIONS-1:0]        rdy_en_cfg,
   input  logic                          ext_ready,
   output logic [2:0]                    bus_state,
   output logic                          data_latch
);
   if (NUM_REGIONS < 1) begin : g_bad_regions
      $error("NUM_REGIONS must be at least 1");
   end
   if (WAIT_W < 1 || WAIT_W > 4) begin : g_bad_wait_w
      $error("WAIT_W must be 1..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [WAIT_W-1:0] sel_wait;
   logic              sel_rdy_en;
   logic              rdy_sync;
   bus_state_e        st;

   bwg_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_ready), .sync_out(rdy_sync)
   );

   bwg_cfg_select #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_sel (
      .region_hit(region_hit), .wait_cfg(wait_cfg), .rdy_en_cfg(rdy_en_cfg),
      .sel_wait(sel_wait), .sel_rdy_en(sel_rdy_en)
   );

   bwg_sequencer #(.WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
      .ld_wait(sel_wait), .ld_rdy_en(sel_rdy_en), .rdy_sync(rdy_sync),
      .state(st)
   );

   assign bus_state  = st;
   assign data_latch = (st == BS_T4);
endmodule

// File: rtl/bwg_chk.sv
module bwg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_start,
   input logic [2:0] bus_state,
   input logic       data_latch
);
   // R2
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state <= 3'd5);
   // R2
   start_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd0 && cyc_start) |=> bus_state == 3'd1);
   // R2
   t1_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state == 3'd1 |=> bus_state == 3'd2);
   // R2
   t2_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state == 3'd2 |=> bus_state == 3'd3);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd0 && !cyc_start) |=> bus_state == 3'd0);
   // R4
   t3_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd3 || bus_state == 3'd4) |=> (bus_state == 3'd4 || bus_state == 3'd5));
   // R8
   t4_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state == 3'd5 |=> bus_state == 3'd0);
   // R8
   latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_latch) |-> ($past(bus_state) == 3'd3 || $past(bus_state) == 3'd4));
   // R8
   latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_latch |=> !data_latch);
endmodule

bind bus_wait_gen bwg_chk u_bwg_chk (
   .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
   .bus_state(bus_state), .data_latch(data_latch)
);

// File: tb/test_bus_wait_gen.sv
`timescale 1ns/1ps
module test_bus_wait_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic [3:0] region_hit = '0;
   logic [7:0] wait_cfg = '0;
   logic [3:0] rdy_en_cfg = '0;
   logic       ext_ready = 1'b0;
   logic [2:0] bus_state;
   logic       data_latch;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_wait_gen i_bus_wait_gen (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .region_hit(region_hit),
      .wait_cfg(wait_cfg), .rdy_en_cfg(rdy_en_cfg), .ext_ready(ext_ready),
      .bus_state(bus_state), .data_latch(data_latch)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ready level before edge j: low inside [a, b), high elsewhere
   function automatic logic fval(input int a, input int b, input int j);
      return !(j >= a && j < b);
   endfunction

   // edge index (T1 entered at edge 0) at which T4 is entered
   function automatic int exp_m(input int w, input bit use_rdy, input int a, input int b);
      for (int k = 3 + w; k < 3 + w + 64; k++)
         if (!use_rdy || fval(a, b, k - 2)) return k;
      return -1;
   endfunction

   task automatic run_txn(input logic [3:0] hit, input logic [7:0] wc, input logic [3:0] en,
                          input int a, input int b, input bit chg, input bit mid,
                          input int expm, input string req);
      int got;
      got = -1;
      region_hit = hit; wait_cfg = wc; rdy_en_cfg = en;
      ext_ready = fval(a, b, -1);
      repeat (3) @(negedge clk);
      cyc_start = 1'b1;
      ext_ready = fval(a, b, 0);
      for (int j = 0; j < 80; j++) begin
         @(posedge clk);
         @(negedge clk);
         cyc_start = (mid && j == 1);
         if (chg && j == 0) begin
            wait_cfg = '0; rdy_en_cfg = '0; region_hit = '0;
         end
         ext_ready = fval(a, b, j + 1);
         if (j == 0) check(bus_state == 3'd1, "R2", bus_state, 1);
         if (j == 1) check(bus_state == 3'd2, "R2", bus_state, 2);
         if (data_latch && got < 0) begin
            got = j;
            check(bus_state == 3'd5, "R8", bus_state, 5);
         end else if (got >= 0) begin
            check(bus_state == 3'd0 && !data_latch, mid ? "R3" : "R8", bus_state, 0);
            break;
         end
      end
      check(got == expm, req, got, expm);
      cyc_start = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      // R1 during reset
      check(bus_state == 3'd0 && !data_latch, "R1", bus_state, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 after release, R3 idle hold
      check(bus_state == 3'd0 && !data_latch, "R1", bus_state, 0);

      // R4 minimum cycle, ready disabled, line low
      run_txn(4'b0001, 8'h00, 4'h0, -100, 100, 0, 0, 3, "R4");
      // R4 three waits in region 2
      run_txn(4'b0100, 8'h30, 4'h0, 0, 0, 0, 0, exp_m(3, 0, 0, 0), "R4");
      // R7 normally-not-ready, ready rises late
      run_txn(4'b0010, 8'h04, 4'h2, -100, 10, 0, 0, exp_m(1, 1, -100, 10), "R7");
      // R7 normally-ready, low pulse across expiry
      run_txn(4'b1000, 8'h40, 4'h8, 2, 9, 0, 0, exp_m(1, 1, 2, 9), "R7");
      // R7 low pulse that ends before expiry has no effect
      run_txn(4'b0001, 8'h03, 4'h1, 0, 3, 0, 0, exp_m(3, 1, 0, 3), "R7");
      // R6 same pulse, enable cleared
      run_txn(4'b1000, 8'h40, 4'h0, 2, 9, 0, 0, exp_m(1, 0, 2, 9), "R6");
      // R6 line low forever, disabled
      run_txn(4'b0010, 8'h08, 4'hD, -100, 100, 0, 0, exp_m(2, 0, 0, 0), "R6");
      // R5 several hits: region 1 (w=2, enabled) beats region 3
      run_txn(4'b1010, 8'h08, 4'h2, -100, 12, 0, 0, exp_m(2, 1, -100, 12), "R5");
      // R5 no hit: zero waits, ready ignored
      run_txn(4'b0000, 8'hFF, 4'hF, -100, 100, 0, 0, 3, "R5");
      // R9 config removed after the start edge
      run_txn(4'b0001, 8'h03, 4'h1, -100, 9, 1, 0, exp_m(3, 1, -100, 9), "R9");
      // R3 stray start mid-cycle
      run_txn(4'b0001, 8'h01, 4'h0, 0, 0, 0, 1, exp_m(1, 0, 0, 0), "R3");

      for (int t = 0; t < 60; t++) begin
         int idx, a, b, w;
         logic [7:0] wc;
         logic [3:0] en;
         idx = $urandom_range(0, 3);
         wc = 8'($urandom);
         en = 4'($urandom);
         w = int'(wc[idx*2 +: 2]);
         if ($urandom_range(0, 1) == 0) begin
            a = -100; b = $urandom_range(0, 12);
         end else begin
            a = $urandom_range(0, 8); b = a + $urandom_range(0, 8);
         end
         run_txn(4'(1 << idx), wc, en, a, b, 0, 0, exp_m(w, en[idx], a, b),
                 en[idx] ? "R7" : "R4");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule